// File: doc/BRIEF.md
# Control/Status Register Bank

This block is the slave side of a simple register bus: an address, a write enable, write data and a registered read-data return. It presents a set of control and status registers to a neighbouring core. Two register kinds live in it. A pass-through register hands each bus write to the core together with a single-cycle strobe, and returns on reads whatever the core drives. A managed register owns its storage. It is built from packed fields, and each field has one access policy for the bus and a separate one for the core.

In the default build the pass-through register sits at address 0. The managed register is 14 bits wide, so it spans two 8-bit words. Its fields are packed upward from bit 0: field 0 is 5 bits and takes bits 4:0; field 1 is 4 bits and takes bits 8:5; field 2 is 3 bits and takes bits 11:9; field 3 is 2 bits and takes bits 13:12. The most significant word comes first. Address 1 carries bits 15:8 and address 2 carries bits 7:0.

Field policies:
- Field 0: bus read-write, core read-only.
- Field 1: bus read-only, core write-only.
- Field 2: bus write-only, core read-only.
- Field 3: read-write on both sides.

Top module: `csr_bank`

## Requirements
- R1: A bus write to address 0 raises `rawStb` for exactly the next cycle, and `rawOut` then carries the written byte. `rawStb` is low in every other cycle.
- R2: A bus read of address 0 returns the value `rawIn` had in the cycle the address was presented.
- R3: `busRdata` always reflects the address presented in the previous cycle; there is no read enable.
- R4: The managed register is split into words with the most significant word first: address 1 reads bits 15:8 and address 2 reads bits 7:0.
- R5: Fields are packed from bit 0 upward in field order. Bits 15:14 of the managed register, and every address other than 0, 1 and 2, read as zero.
- R6: Bus writes leave a bus read-only field (field 1) unchanged. A bus write-only field (field 2) reads back on the bus as zero.
- R7: `fieldOut` (same bit layout as the register) shows the current stored value of every core-readable field (0, 2, 3) at all times. The bits of the core write-only field 1 are zero.
- R8: When `fieldWe[f]` is high, a core-writable field f (1 or 3) loads its slice of `fieldIn` at the clock edge. For fields 0 and 2, `fieldWe[f]` has no effect.
- R9: When the bus and the core write the same field in the same cycle, the core value is stored.
- R10: After reset all fields, `busRdata`, `rawOut` and `rawStb` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 4 | Bus register address |
| busWe | input | 1 | Bus write enable for the addressed word |
| busWdata | input | 8 | Bus write data |
| busRdata | output | 8 | Read data for the previous cycle's address |
| rawOut | output | 8 | Last bus-written pass-through value, valid while `rawStb` is high |
| rawStb | output | 1 | One-cycle strobe after a pass-through write |
| rawIn | input | 8 | Core-supplied read value of the pass-through register |
| fieldOut | output | 14 | Core view of the core-readable fields |
| fieldIn | input | 14 | Core write data, register bit layout |
| fieldWe | input | 4 | Per-field core write enables, bit f for field f |

## Verification
If a field's stored bits are wrong, the error shows on `fieldOut` in the cycle after the faulty edge whenever the field is core-readable. For a field that is only bus-readable, the error appears one cycle after the bus next reads its word. A wrong decode shows up as a byte read from the wrong place on `busRdata`, or as a strobe in a cycle with no pass-through write, one cycle after the access. Because the bench model runs alongside the design and is compared on every clock, a corrupted word surfaces at the first read or core-view cycle that exposes it.

// File: rtl/csr_bank_pkg.sv
package csr_bank_pkg;

  localparam int BUS_W  = 8;
  localparam int RAW_W  = 8;
  localparam int NFIELD = 4;

  typedef enum logic [1:0] {
    ACC_RO = 2'd0,
    ACC_WO = 2'd1,
    ACC_RW = 2'd2
  } acc_e;

  localparam int   FLD_W    [NFIELD] = '{5, 4, 3, 2};
  localparam acc_e FLD_BUS  [NFIELD] = '{ACC_RW, ACC_RO, ACC_WO, ACC_RW};
  localparam acc_e FLD_CORE [NFIELD] = '{ACC_RO, ACC_WO, ACC_RO, ACC_RW};

  function automatic int fldLsb(input int idx);
    int s;
    s = 0;
    for (int i = 0; i < idx; i++) s += FLD_W[i];
    return s;
  endfunction

  function automatic bit canRd(input acc_e a);
    return a != ACC_WO;
  endfunction

  function automatic bit canWr(input acc_e a);
    return a != ACC_RO;
  endfunction

  localparam int PACK_W = fldLsb(NFIELD);
  localparam int NWORDS = (PACK_W + BUS_W - 1) / BUS_W;
  localparam int REG_W  = NWORDS * BUS_W;

  // per-bit policy mask; coreSide selects which policy table, wr selects write or read
  function automatic logic [PACK_W-1:0] buildMask(input bit coreSide, input bit wr);
    logic [PACK_W-1:0] m;
    acc_e a;
    bit   ok;
    m = '0;
    for (int f = 0; f < NFIELD; f++) begin
      a  = coreSide ? FLD_CORE[f] : FLD_BUS[f];
      ok = wr ? canWr(a) : canRd(a);
      if (ok) begin
        for (int b = 0; b < FLD_W[f]; b++) m[fldLsb(f) + b] = 1'b1;
      end
    end
    return m;
  endfunction

  localparam logic [PACK_W-1:0] BUS_WR_MASK  = buildMask(1'b0, 1'b1);
  localparam logic [PACK_W-1:0] BUS_RD_MASK  = buildMask(1'b0, 1'b0);
  localparam logic [PACK_W-1:0] CORE_RD_MASK = buildMask(1'b1, 1'b0);

  typedef struct packed {
    logic              rawWr;
    logic              rawRd;
    logic [NWORDS-1:0] wordWr;
    logic [NWORDS-1:0] wordRd;
  } strobe_t;

endpackage

// File: rtl/csr_bank_ctrl.sv
module csr_bank_ctrl
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RAW_ADDR = 0,
  parameter int MGD_BASE = 1
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strb
);

  logic              rawSel;
  logic [NWORDS-1:0] wordSel;

  assign rawSel = (busAddr == ADDR_W'(RAW_ADDR));

  // lowest address holds the most significant word
  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    localparam int WI = NWORDS - 1 - k;
    assign wordSel[WI] = (busAddr == ADDR_W'(MGD_BASE + k));
  end

  always_comb begin
    strb.rawRd  = rawSel;
    strb.rawWr  = rawSel & busWe;
    strb.wordRd = wordSel;
    strb.wordWr = wordSel & {NWORDS{busWe}};
  end

endmodule

// File: rtl/csr_bank_field.sv
module csr_bank_field #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] busEn,
  input  logic [W-1:0] busData,
  input  logic         coreEn,
  input  logic [W-1:0] coreData,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       q <= '0;
    else if (coreEn) q <= coreData;
    else             q <= (q & ~busEn) | (busData & busEn);
  end

  // R9
  core_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreEn |=> q == $past(coreData));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!coreEn && busEn == '0) |=> $stable(q));

endmodule

// File: rtl/csr_bank_dp.sv
module csr_bank_dp
  import csr_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [BUS_W-1:0]  busWdata,
  input  logic [RAW_W-1:0]  rawIn,
  input  logic [PACK_W-1:0] fieldIn,
  input  logic [NFIELD-1:0] fieldWe,
  output logic [BUS_W-1:0]  busRdata,
  output logic [RAW_W-1:0]  rawOut,
  output logic              rawStb,
  output logic [PACK_W-1:0] fieldOut
);

  logic [PACK_W-1:0] busEn;
  logic [PACK_W-1:0] busData;
  logic [PACK_W-1:0] storeQ;
  logic [REG_W-1:0]  rdView;
  logic [BUS_W-1:0]  rdNext;

  // expand word write strobes to bits, gated by bus write policy
  always_comb begin
    for (int b = 0; b < PACK_W; b++) begin
      busEn[b]   = strb.wordWr[b / BUS_W] & BUS_WR_MASK[b];
      busData[b] = busWdata[b % BUS_W];
    end
  end

  for (genvar f = 0; f < NFIELD; f++) begin : g_fld
    localparam int LSB = fldLsb(f);
    localparam int W   = FLD_W[f];
    localparam bit CW  = canWr(FLD_CORE[f]);
    logic coreEn;
    assign coreEn = fieldWe[f] & CW;
    csr_bank_field #(.W(W)) u_fld (
      .clk      (clk),
      .rstN     (rstN),
      .busEn    (busEn[LSB +: W]),
      .busData  (busData[LSB +: W]),
      .coreEn   (coreEn),
      .coreData (fieldIn[LSB +: W]),
      .q        (storeQ[LSB +: W])
    );
  end

  assign fieldOut = storeQ & CORE_RD_MASK;
  assign rdView   = REG_W'(storeQ & BUS_RD_MASK);

  always_comb begin
    rdNext = '0;
    if (strb.rawRd) rdNext = BUS_W'(rawIn);
    for (int w = 0; w < NWORDS; w++) begin
      if (strb.wordRd[w]) rdNext = rdNext | rdView[w*BUS_W +: BUS_W];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdata <= '0;
      rawOut   <= '0;
      rawStb   <= 1'b0;
    end else begin
      busRdata <= rdNext;
      rawStb   <= strb.rawWr;
      if (strb.rawWr) rawOut <= busWdata[RAW_W-1:0];
    end
  end

  // R1
  raw_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rawWr |=> rawStb && rawOut == $past(busWdata[RAW_W-1:0]));

  // R1
  raw_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.rawWr |=> !rawStb);

  // R2
  raw_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.rawRd |=> busRdata == BUS_W'($past(rawIn)));

  // R5
  decode_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rawRd, strb.wordRd}));

  // R5
  idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rawRd || (|strb.wordRd)) |=> busRdata == '0);

endmodule

// File: rtl/csr_bank.sv
module csr_bank
  import csr_bank_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int RAW_ADDR = 0,
  parameter int MGD_BASE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [BUS_W-1:0]  busWdata,
  output logic [BUS_W-1:0]  busRdata,
  output logic [RAW_W-1:0]  rawOut,
  output logic              rawStb,
  input  logic [RAW_W-1:0]  rawIn,
  output logic [PACK_W-1:0] fieldOut,
  input  logic [PACK_W-1:0] fieldIn,
  input  logic [NFIELD-1:0] fieldWe
);

  strobe_t strb;

  csr_bank_ctrl #(
    .ADDR_W   (ADDR_W),
    .RAW_ADDR (RAW_ADDR),
    .MGD_BASE (MGD_BASE)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strb    (strb)
  );

  csr_bank_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .busWdata (busWdata),
    .rawIn    (rawIn),
    .fieldIn  (fieldIn),
    .fieldWe  (fieldWe),
    .busRdata (busRdata),
    .rawOut   (rawOut),
    .rawStb   (rawStb),
    .fieldOut (fieldOut)
  );

endmodule

// File: tb/csr_bank_bench.sv
`timescale 1ns/1ps
module csr_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busWdata = '0;
  logic [7:0]  busRdata;
  logic [7:0]  rawOut;
  logic        rawStb;
  logic [7:0]  rawIn = '0;
  logic [13:0] fieldOut;
  logic [13:0] fieldIn = '0;
  logic [3:0]  fieldWe = '0;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  csr_bank u_csr_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .rawOut(rawOut),
    .rawStb(rawStb), .rawIn(rawIn), .fieldOut(fieldOut),
    .fieldIn(fieldIn), .fieldWe(fieldWe)
  );

  // behavioural reference
  localparam int MW   [4] = '{5, 4, 3, 2};
  localparam int MLSB [4] = '{0, 5, 9, 12};
  localparam bit BWR  [4] = '{1, 0, 1, 1};
  localparam bit BRD  [4] = '{1, 1, 0, 1};
  localparam bit CWR  [4] = '{0, 1, 0, 1};
  localparam bit CRD  [4] = '{1, 0, 1, 1};

  int mF [4] = '{0, 0, 0, 0};
  int mRd = 0;
  int mRaw = 0;
  bit mStb = 1'b0;

  function automatic int image(input int sel);
    int v;
    v = 0;
    for (int f = 0; f < 4; f++) begin
      if (sel == 0 && BRD[f]) v |= mF[f] << MLSB[f];
      if (sel == 1 && CRD[f]) v |= mF[f] << MLSB[f];
      if (sel == 2)           v |= mF[f] << MLSB[f];
    end
    return v;
  endfunction

  always @(posedge clk) begin
    int nv;
    if (!rstN) begin
      for (int f = 0; f < 4; f++) mF[f] = 0;
      mRd = 0; mRaw = 0; mStb = 1'b0;
    end else begin
      if (busAddr == 0)      mRd = rawIn;
      else if (busAddr == 1) mRd = (image(0) >> 8) & 'hFF;
      else if (busAddr == 2) mRd = image(0) & 'hFF;
      else                   mRd = 0;
      mStb = busWe && busAddr == 0;
      if (mStb) mRaw = busWdata;
      if (busWe && (busAddr == 1 || busAddr == 2)) begin
        nv = (busAddr == 1) ? ((image(2) & 'hFF) | (int'(busWdata) << 8))
                            : ((image(2) & 'hFF00) | int'(busWdata));
        for (int f = 0; f < 4; f++)
          if (BWR[f]) mF[f] = (nv >> MLSB[f]) & ((1 << MW[f]) - 1);
      end
      for (int f = 0; f < 4; f++)
        if (CWR[f] && fieldWe[f]) mF[f] = (int'(fieldIn) >> MLSB[f]) & ((1 << MW[f]) - 1);
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare against the model on every clock
  always @(negedge clk) begin
    if (!finished) begin
      check(busRdata == mRd[7:0], "R3 read data", busRdata, mRd);
      check(fieldOut == image(1), "R7 core view", fieldOut, image(1));
      check(rawStb == mStb, "R1 strobe", rawStb, mStb);
      if (mStb) check(rawOut == mRaw[7:0], "R1 raw data", rawOut, mRaw);
    end
  end

  task automatic cyc(input int a, input bit we, input int wd,
                     input int fwe, input int fin, input int rin);
    busAddr = a[3:0]; busWe = we; busWdata = wd[7:0];
    fieldWe = fwe[3:0]; fieldIn = fin[13:0]; rawIn = rin[7:0];
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busRdata == 0, "R10 rdata", busRdata, 0);
    check(fieldOut == 0, "R10 fields", fieldOut, 0);
    check(rawStb == 0, "R10 strobe", rawStb, 0);
    rstN = 1'b1;
    cyc(2, 0, 0, 0, 0, 0);
    check(busRdata == 0, "R10 stored zero", busRdata, 0);
    cyc(0, 1, 'h5A, 0, 0, 0);
    check(rawStb == 1 && rawOut == 'h5A, "R1 pulse", rawOut, 'h5A);
    cyc(7, 0, 0, 0, 0, 0);
    check(rawStb == 0, "R1 single cycle", rawStb, 0);
    check(busRdata == 0, "R5 unmapped address", busRdata, 0);
    cyc(0, 0, 0, 0, 0, 'hC3);
    check(busRdata == 'hC3, "R2 raw read", busRdata, 'hC3);
    cyc(1, 1, 'hFF, 0, 0, 0);
    cyc(2, 1, 'hFF, 0, 0, 0);
    cyc(1, 0, 0, 0, 0, 0);
    check(busRdata == 'h30, "R4 R6 upper word", busRdata, 'h30);
    cyc(2, 0, 0, 0, 0, 0);
    check(busRdata == 'h1F, "R4 R5 lower word", busRdata, 'h1F);
    check(fieldOut == 'h3E1F, "R7 core view", fieldOut, 'h3E1F);
    cyc(7, 0, 0, 'b0010, 'h140, 0);
    cyc(2, 0, 0, 0, 0, 0);
    check(busRdata == 'h5F, "R8 core write lower", busRdata, 'h5F);
    cyc(1, 0, 0, 0, 0, 0);
    check(busRdata == 'h31, "R8 core write upper", busRdata, 'h31);
    check(fieldOut == 'h3E1F, "R7 write-only hidden", fieldOut, 'h3E1F);
    cyc(7, 0, 0, 'b0101, 0, 0);
    check(fieldOut == 'h3E1F, "R8 read-only ignored", fieldOut, 'h3E1F);
    cyc(1, 1, 'h00, 'b1000, 'h2000, 0);
    check(fieldOut == 'h201F, "R9 core wins", fieldOut, 'h201F);
    cyc(1, 0, 0, 0, 0, 0);
    check(busRdata == 'h21, "R9 R6 after conflict", busRdata, 'h21);
    for (int i = 0; i < 600; i++)
      cyc($urandom % 8, 1'($urandom), $urandom, $urandom, $urandom, $urandom);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule